// File: doc/BRIEF.md
# Serial Multiply-Accumulate Neuron with Bias Preset

This block is one neuron of a layer in which every neuron listens to the same serial input line. On each clock cycle the previous layer presents one signed fixed-point value. The neuron multiplies that value by a weight taken from its own constant weight table, and adds the product into a wide accumulator. The table is indexed by an address bus that a layer sequencer shares among all neurons. A computation takes as many enabled cycles as there are incoming connections, and the hardware does not change with that count.

Before each computation the sequencer pulses a load control. This presets the accumulator with the neuron's bias, rescaled to the product's format. Once all inputs have been accumulated, an output-enable control places the accumulator value on the layer's shared output. Only one neuron is enabled at a time. The shared output is modelled as a gated contribution with a valid flag, so the layer ORs the outputs of its neurons together.

Inputs, weights and bias use 8-bit two's complement with 6 fraction bits. This covers [-2, 2) in steps of 1/64: 1.0 is 0x40, -1.0 is 0xC0, -2.0 is 0x80 and 1.984375 is 0x7F. Products and the accumulator use 16 bits with 12 fraction bits.

Top module: `mac_neuron`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, the accumulator is zero. Reset is asynchronous and active low.
- R2: A clock edge with `load` high sets the accumulator to the 8-bit `BIAS` sign-extended to 16 bits and multiplied by 64. For example, a bias of 0x20 gives 0x0800.
- R3: When `load` and `acc_en` are both high, only the load takes effect.
- R4: A clock edge with `acc_en` high and `load` low adds the signed 16-bit product of `in_data` and table entry `weight_addr` to the accumulator. The entry is read combinationally in the same cycle. Entry k occupies bits [8k+7:8k] of `WEIGHT_INIT`.
- R5: With `load` and `acc_en` both low, the accumulator holds its value. The values of `in_data` and `weight_addr` have no effect.
- R6: With `SATURATE` = 0, a sum outside the 16-bit signed range wraps modulo 2^16.
- R7: With `SATURATE` = 1, a sum above 32767 becomes 32767 and a sum below -32768 becomes -32768. Later additions start from the clamped value.
- R8: With `out_en` low, `out_data` is zero and `out_valid` is low. With `out_en` high, `out_data` equals the accumulator and `out_valid` is high, in the same cycle. `out_en` never alters the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DW (8) | Serial input value, signed 2.6 |
| weight_addr | input | AW (4) | Shared weight table index |
| load | input | 1 | Preset accumulator with bias |
| acc_en | input | 1 | Accumulate one product this cycle |
| out_en | input | 1 | Drive accumulator onto shared output |
| out_data | output | 2*DW (16) | Accumulator value when enabled, else zero |
| out_valid | output | 1 | High while this neuron drives the output |

## Verification
The bench builds two copies of the block that differ only in `SATURATE` and drives both with the same stimulus. This puts wrap-around and clamping side by side, at both the positive and the negative extreme. Both copies use 8-bit data with a 16-entry table. The weights include -2.0, -1.0, 0, 1/64 and 1.984375, and the bias is 0.5. This brings the largest products of both signs within reach, so a few additions cross the 16-bit limits. A mid-run reset and the case where load and enable coincide are driven by directed steps.

// File: rtl/nrn_pkg.sv
package nrn_pkg;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_ADD  = 2'd2
  } acc_op_e;

  // Priority decode: a preset always beats accumulation.
  function automatic acc_op_e decode_op(input logic ld, input logic en);
    if (ld)      return ACC_LOAD;
    else if (en) return ACC_ADD;
    else         return ACC_HOLD;
  endfunction

endpackage

// File: rtl/nrn_weight_rom.sv
module nrn_weight_rom #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_w[g] = INIT[g*DW +: DW];
  end

  assign data = table_w[addr];
endmodule

// File: rtl/nrn_mult.sv
module nrn_mult #(
  parameter int DW = 8
) (
  input  logic signed [DW-1:0]   a,
  input  logic signed [DW-1:0]   b,
  output logic signed [2*DW-1:0] p
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  assign a_ext = PW'(a);
  assign b_ext = PW'(b);
  assign p     = a_ext * b_ext;
endmodule

// File: rtl/nrn_accum.sv
module nrn_accum
  import nrn_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter bit SATURATE = 1'b0,
  parameter logic [ACC_W-1:0] PRESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_op_e          op,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W:0]   sum_wide;
  logic             ovf;
  logic [ACC_W-1:0] sum_fit;

  assign sum_wide = {acc[ACC_W-1], acc} + {addend[ACC_W-1], addend};
  assign ovf      = sum_wide[ACC_W] ^ sum_wide[ACC_W-1];

  if (SATURATE) begin : g_clamp
    assign sum_fit = ovf ? (sum_wide[ACC_W] ? MAX_NEG : MAX_POS)
                         : sum_wide[ACC_W-1:0];
  end else begin : g_wrap
    assign sum_fit = sum_wide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else begin
      unique case (op)
        ACC_LOAD: acc <= PRESET;
        ACC_ADD:  acc <= sum_fit;
        default:  acc <= acc;
      endcase
    end
  end
endmodule

// File: rtl/nrn_out_stage.sv
module nrn_out_stage #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] value,
  output logic [W-1:0] bus,
  output logic         valid
);
  assign bus   = en ? value : '0;
  assign valid = en;
endmodule

// File: rtl/mac_neuron.sv
module mac_neuron
  import nrn_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter bit SATURATE = 1'b0,
  parameter logic [DW-1:0] BIAS = '0,
  parameter logic [(1<<AW)*DW-1:0] WEIGHT_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   in_data,
  input  logic [AW-1:0]   weight_addr,
  input  logic            load,
  input  logic            acc_en,
  input  logic            out_en,
  output logic [2*DW-1:0] out_data,
  output logic            out_valid
);
  localparam int ACC_W = 2 * DW;
  localparam int FRAC  = DW - 2;
  localparam logic [ACC_W-1:0] BIAS_EXT =
    ACC_W'($signed(BIAS)) << FRAC;

  logic [DW-1:0]    weight;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] acc_q;
  acc_op_e          op;

  nrn_weight_rom #(.DW(DW), .AW(AW), .INIT(WEIGHT_INIT)) u_rom (
    .addr (weight_addr),
    .data (weight)
  );

  nrn_mult #(.DW(DW)) u_mult (
    .a (in_data),
    .b (weight),
    .p (prod)
  );

  assign op = decode_op(load, acc_en);

  nrn_accum #(.ACC_W(ACC_W), .SATURATE(SATURATE), .PRESET(BIAS_EXT)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .addend (prod),
    .acc    (acc_q)
  );

  nrn_out_stage #(.W(ACC_W)) u_out (
    .en    (out_en),
    .value (acc_q),
    .bus   (out_data),
    .valid (out_valid)
  );
endmodule

// File: rtl/nrn_checker.sv
module nrn_checker #(
  parameter int W = 16,
  parameter bit SATURATE = 1'b0,
  parameter logic [W-1:0] PRESET = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         acc_en,
  input logic         out_en,
  input logic [W-1:0] prod,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] out_data,
  input logic         out_valid
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_q == '0); // R1

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> acc_q == PRESET); // R2

  AST_LOAD_BEATS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (load && acc_en) |=> acc_q == PRESET); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !acc_en) |=> $stable(acc_q)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && acc_en && !load && !acc_q[W-1] && !prod[W-1])
      |=> !acc_q[W-1]); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && acc_en && !load && acc_q[W-1] && prod[W-1])
      |=> acc_q[W-1]); // R7

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (out_data == '0 && !out_valid)); // R8

  AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (out_valid && out_data == acc_q)); // R8
endmodule

bind mac_neuron nrn_checker #(
  .W(ACC_W), .SATURATE(SATURATE), .PRESET(BIAS_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .acc_en(acc_en), .out_en(out_en),
  .prod(prod), .acc_q(acc_q), .out_data(out_data), .out_valid(out_valid)
);

// File: tb/mac_neuron_tb.sv
module mac_neuron_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [7:0] BIAS = 8'h20;
  // entries 15..0
  localparam logic [16*8-1:0] WTS = {
    8'hF8, 8'h08, 8'h80, 8'h7F, 8'hF0, 8'h10, 8'hE0, 8'h2F,
    8'hFF, 8'h01, 8'h00, 8'h20, 8'h80, 8'h7F, 8'hC0, 8'h40};

  // {load, acc_en, out_en, addr[3:0], in[7:0]}
  localparam int NV = 17;
  localparam logic [14:0] VEC [NV] = '{
    {3'b101, 4'd0,  8'h00}, {3'b011, 4'd0,  8'h40}, {3'b011, 4'd1,  8'h40},
    {3'b011, 4'd4,  8'hC0}, {3'b011, 4'd7,  8'h01}, {3'b001, 4'd9,  8'h55},
    {3'b000, 4'd3,  8'h80}, {3'b010, 4'd8,  8'h2F}, {3'b001, 4'd0,  8'h00},
    {3'b111, 4'd2,  8'h7F}, {3'b011, 4'd5,  8'h7F}, {3'b011, 4'd3,  8'h80},
    {3'b011, 4'd9,  8'h10}, {3'b011, 4'd15, 8'h7F}, {3'b100, 4'd0,  8'h00},
    {3'b011, 4'd14, 8'h80}, {3'b001, 4'd6,  8'h33}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] weight_addr = '0;
  logic load = 1'b0, acc_en = 1'b0, out_en = 1'b0;
  logic [15:0] out_w, out_s;
  logic vld_w, vld_s;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int m_w = 0;
  int m_s = 0;

  always #10 clk = ~clk;

  mac_neuron #(.DW(DW), .AW(AW), .SATURATE(1'b0), .BIAS(BIAS), .WEIGHT_INIT(WTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .weight_addr(weight_addr),
    .load(load), .acc_en(acc_en), .out_en(out_en), .out_data(out_w), .out_valid(vld_w));

  mac_neuron #(.DW(DW), .AW(AW), .SATURATE(1'b1), .BIAS(BIAS), .WEIGHT_INIT(WTS)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .weight_addr(weight_addr),
    .load(load), .acc_en(acc_en), .out_en(out_en), .out_data(out_s), .out_valid(vld_s));

  function automatic int model_step(int acc, logic ld, logic en, logic [7:0] x,
                                    logic [3:0] a, bit sat);
    int xi, wi, s;
    if (ld) return int'($signed(BIAS)) * 64;
    if (!en) return acc;
    xi = int'($signed(x));
    wi = int'($signed(WTS[a*8 +: 8]));
    s = acc + xi * wi;
    if (sat) begin
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
    end
    return int'($signed(16'(s)));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    chk(tag, int'($signed(out_w)), out_en ? m_w : 0);
    chk(tag, int'($signed(out_s)), out_en ? m_s : 0);
    chk("R8", int'(vld_w), int'(out_en));
    chk("R8", int'(vld_s), int'(out_en));
  endtask

  task automatic step(logic ld, logic en, logic oe, logic [3:0] a, logic [7:0] x,
                      string tag);
    load = ld; acc_en = en; out_en = oe; weight_addr = a; in_data = x;
    m_w = model_step(m_w, ld, en, x, a, 1'b0);
    m_s = model_step(m_s, ld, en, x, a, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check_outs(tag);
  endtask

  initial begin
    // R1: reset state, observed through the output with out_en high
    out_en = 1'b1;
    repeat (3) @(negedge clk);
    check_outs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      string tag;
      v = VEC[i];
      if (v[14] && v[13]) tag = "R3";
      else if (v[14]) tag = "R2";
      else if (v[13]) tag = "R4";
      else tag = "R5";
      step(v[14], v[13], v[12], v[11:8], v[7:0], tag);
    end

    // R6/R7: positive overflow: wrap vs clamp, then recover from clamp
    step(1'b1, 1'b0, 1'b1, 4'd0, 8'h00, "R2");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h7F, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h7F, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h7F, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h80, "R7");
    // negative overflow
    step(1'b1, 1'b0, 1'b1, 4'd0, 8'h00, "R2");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h80, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h80, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd2, 8'h80, "R6_R7");
    step(1'b0, 1'b1, 1'b1, 4'd3, 8'h80, "R7");
    // -2 * -2 = largest positive product
    step(1'b0, 1'b1, 1'b1, 4'd13, 8'h80, "R4");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    load = 1'b0; acc_en = 1'b1; out_en = 1'b1; weight_addr = 4'd0; in_data = 8'h40;
    #3 rst_n = 1'b0;
    #2;
    m_w = 0; m_s = 0;
    check_outs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    acc_en = 1'b0;
    @(negedge clk);
    check_outs("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule